// File: doc/BRIEF.md
# Truncated Signed Tree Multiplier

This block multiplies two N-bit two's complement operands but builds only part of the partial-product matrix. The R lowest weight columns are never generated. The formed bits are compressed by carry-save adders and resolved by one carry-propagate adder. The result keeps the upper N+K bits of the 2N-bit product, so K bits of extra precision sit below the N-bit result.

Omitting columns leaves a sum that is biased low. To cancel that bias, a constant is computed at elaboration from N, R and K and added with the formed bits. The constant is the expected value of the missing bits, rounded to the weight of the least significant retained bit. The partial products use the inverted-MSB sign form with two constant ones, so every formed bit adds as an unsigned bit.

A second output gives an N-bit result, rounded to nearest from the (N+K)-bit result. An elaboration switch puts one register on both outputs or leaves the path purely combinational. The block suits datapaths such as filter taps, where a small, nearly zero-mean error is worth the area saved.

Top module: `trunc_mul`

## Requirements
- R1: With OUT_REG=1, both outputs read zero on the clock edge after any edge at which rst_n is low. With OUT_REG=0 the outputs follow the operands in the same cycle.
- R2: prod equals bits [2N-1:N-K] of (P - L + C) mod 2^(2N). P is the signed product. L is the sum of a[i]·b[j]·2^(i+j) over all i+j < R. C is the correction constant. With OUT_REG=1 it appears one cycle after the operands.
- R3: C equals round(((R-1)·2^(R-2) + 1/4) / 2^(N-K)) · 2^(N-K), with halves rounding up, and C is 0 when R is 0. When either operand is zero, prod equals C / 2^(N-K).
- R4: Let the error be prod·2^(N-K) - P, with prod read as signed. It lies in (C - Lmax - 2^(N-K), C], where Lmax = (R-1)·2^R + 1.
- R5: prod_rnd equals bits [N+K-1:K] of prod + 2^(K-1), computed modulo 2^(N+K). When K is 0, prod_rnd equals prod.
- R6: Over many uniformly random operand pairs, the mean of the R4 error has a magnitude of at most one unit of 2^(N-K).
- R7: Products at the range limits are exact up to truncation, including the most negative value squared. For N=8, R=5, K=2, -128 × -128 gives prod = 0x101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier, two's complement |
| prod | output | N+K | Truncated product, bits 2N-1 down to N-K of the corrected sum |
| prod_rnd | output | N | prod rounded to nearest at N bits |

## Verification
The bench aims at sign handling at the range limits, where a wrong inverted-bit or constant-one placement shows up as a product off by a large power of two. It also targets the zero-operand case, which exposes a mis-rounded or missing correction constant as a result off by one unit. Random operands are compared bit-for-bit against a full product minus the dropped low columns. This catches a formed/unformed boundary shifted by one column, because the carries reaching the kept bits change. A mean-error sweep catches a constant left out or applied at the wrong weight, since the average bias then grows to about one unit or more.

// File: rtl/tmul_pkg.sv
// Shared elaboration-time helpers for the truncated multiplier.
// Assumes N <= 31 so the 2N-bit arithmetic fits in a longint.
package tmul_pkg;

    // Bias constant: rounded expected value of the dropped columns, in product units.
    function automatic longint tmul_corr(input int n, input int r, input int k);
        longint e4;
        longint u;
        if (r == 0) begin
            return 0;
        end
        e4 = longint'(r - 1) * (longint'(1) << r) + 1;   // four times the expectation
        u  = longint'(1) << (n - k);
        return ((e4 + 2 * u) >> (n - k + 2)) << (n - k);
    endfunction

    // Largest possible value of the dropped columns.
    function automatic longint tmul_lmax(input int r);
        if (r == 0) begin
            return 0;
        end
        return longint'(r - 1) * (longint'(1) << r) + 1;
    endfunction

endpackage

// File: rtl/tmul_ppgen.sv
// Partial-product matrix generator for a signed N x N product.
// Uses the inverted-MSB sign form: a bit that pairs exactly one sign bit
// with a non-sign bit is complemented. One extra row carries the two
// sign-form constant ones plus the correction constant. Columns below R
// are forced to zero, so they cost no logic. Assumes R <= N-1, which
// means every dropped bit is an ordinary AND term.
module tmul_ppgen #(
    parameter int N = 8,
    parameter int R = 5,
    parameter int K = 2,
    localparam int W = 2 * N,
    localparam int ROWS = N + 1
) (
    input  logic [N-1:0]            mul_a,
    input  logic [N-1:0]            mul_b,
    output logic [ROWS-1:0][W-1:0]  pp_rows
);
    localparam longint CORR   = tmul_pkg::tmul_corr(N, R, K);
    localparam longint CROW_L = (longint'(1) << N) + (longint'(1) << (W - 1)) + CORR;
    localparam logic [63:0] CROW_64 = CROW_L;
    localparam logic [W-1:0] CROW = CROW_64[W-1:0];

    for (genvar j = 0; j < N; j++) begin : g_row
        for (genvar c = 0; c < W; c++) begin : g_col
            if (c < R || c < j || c > j + N - 1) begin : g_empty
                assign pp_rows[j][c] = 1'b0;
            end else if ((c - j == N - 1) != (j == N - 1)) begin : g_inv
                assign pp_rows[j][c] = ~(mul_a[c-j] & mul_b[j]);
            end else begin : g_plain
                assign pp_rows[j][c] = mul_a[c-j] & mul_b[j];
            end
        end
    end

    assign pp_rows[N] = CROW;

endmodule

// File: rtl/tmul_csa_reduce.sv
// Carry-save reduction of ROWS vectors down to a sum and a carry vector.
// Each stage is one 3:2 counter across all columns. Carries out of the
// top column are dropped, which gives arithmetic modulo 2^W.
// Assumes ROWS >= 3.
module tmul_csa_reduce #(
    parameter int W = 16,
    parameter int ROWS = 9
) (
    input  logic [ROWS-1:0][W-1:0] in_rows,
    output logic [W-1:0]           red_sum,
    output logic [W-1:0]           red_cry
);
    logic [ROWS-1:0][W-1:0] st_s;
    logic [ROWS-1:0][W-1:0] st_c;

    assign st_s[1] = in_rows[0];
    assign st_c[1] = in_rows[1];
    assign st_s[0] = '0;
    assign st_c[0] = '0;

    for (genvar t = 2; t < ROWS; t++) begin : g_stage
        // One 3:2 compression of the running pair with the next row.
        assign st_s[t] = st_s[t-1] ^ st_c[t-1] ^ in_rows[t];
        assign st_c[t] = {((st_s[t-1][W-2:0] & st_c[t-1][W-2:0]) |
                           (st_s[t-1][W-2:0] & in_rows[t][W-2:0]) |
                           (st_c[t-1][W-2:0] & in_rows[t][W-2:0])), 1'b0};
    end

    assign red_sum = st_s[ROWS-1];
    assign red_cry = st_c[ROWS-1];

endmodule

// File: rtl/tmul_final.sv
// Final carry-propagate addition, truncation to the top N+K bits, and
// round-to-nearest down to N bits. The carry from the discarded low bits
// still reaches the kept bits.
module tmul_final #(
    parameter int N = 8,
    parameter int K = 2,
    localparam int W = 2 * N,
    localparam int OW = N + K
) (
    input  logic [W-1:0]  fin_sum,
    input  logic [W-1:0]  fin_cry,
    output logic [OW-1:0] fin_trunc,
    output logic [N-1:0]  fin_rnd
);
    // Full-width add; only the upper OW bits are returned.
    function automatic logic [OW-1:0] add_keep(input logic [W-1:0] s, input logic [W-1:0] c);
        logic [W-1:0] tot;
        tot = s + c;
        return tot[W-1:W-OW];
    endfunction

    // Add half of the discarded K-bit weight, then drop K bits.
    function automatic logic [N-1:0] round_k(input logic [OW-1:0] v);
        logic [OW-1:0] tmp;
        tmp = v + (OW'(1) << (K - 1));
        return tmp[OW-1:K];
    endfunction

    assign fin_trunc = add_keep(fin_sum, fin_cry);

    if (K > 0) begin : g_round
        assign fin_rnd = round_k(fin_trunc);
    end else begin : g_pass
        assign fin_rnd = fin_trunc[N-1:0];
    end

endmodule

// File: rtl/trunc_mul.sv
// Truncated signed multiplier top level.
// Assumes 2 <= N <= 31, R <= N-1 and R + K <= N. OUT_REG=1 registers
// both outputs, with a synchronous active-low reset; OUT_REG=0 leaves
// the path combinational.
module trunc_mul #(
    parameter int N = 8,
    parameter int R = 5,
    parameter int K = 2,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     op_a,
    input  logic [N-1:0]     op_b,
    output logic [N+K-1:0]   prod,
    output logic [N-1:0]     prod_rnd
);
    localparam int W = 2 * N;
    localparam int ROWS = N + 1;

    logic [ROWS-1:0][W-1:0] rows;
    logic [W-1:0]           csa_s;
    logic [W-1:0]           csa_c;
    logic [N+K-1:0]         trunc_d;
    logic [N-1:0]           rnd_d;

    tmul_ppgen #(.N(N), .R(R), .K(K)) u_ppgen (
        .mul_a  (op_a),
        .mul_b  (op_b),
        .pp_rows(rows)
    );

    tmul_csa_reduce #(.W(W), .ROWS(ROWS)) u_reduce (
        .in_rows(rows),
        .red_sum(csa_s),
        .red_cry(csa_c)
    );

    tmul_final #(.N(N), .K(K)) u_final (
        .fin_sum  (csa_s),
        .fin_cry  (csa_c),
        .fin_trunc(trunc_d),
        .fin_rnd  (rnd_d)
    );

    if (OUT_REG) begin : g_oreg
        // Output register: clear on reset, else capture the new product.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod     <= '0;
                prod_rnd <= '0;
            end else begin
                prod     <= trunc_d;
                prod_rnd <= rnd_d;
            end
        end
    end else begin : g_comb
        assign prod     = trunc_d;
        assign prod_rnd = rnd_d;
    end

endmodule

// File: rtl/trunc_mul_chk.sv
// Property checker for trunc_mul, attached by bind. It realigns the
// operands to the output latency and checks the outputs against bounds
// derived from the signed product.
module trunc_mul_chk #(
    parameter int N = 8,
    parameter int R = 5,
    parameter int K = 2,
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   op_a,
    input logic [N-1:0]   op_b,
    input logic [N+K-1:0] prod,
    input logic [N-1:0]   prod_rnd
);
    localparam longint C    = tmul_pkg::tmul_corr(N, R, K);
    localparam longint LMAX = tmul_pkg::tmul_lmax(R);
    localparam longint ULP  = longint'(1) << (N - K);
    localparam longint CQ   = C >> (N - K);
    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
    localparam longint MAXSQ = ((longint'(1) << (2 * N - 2)) + C) >> (N - K);

    logic [N-1:0] a_q;
    logic [N-1:0] b_q;
    logic         vld;
    longint       err;

    if (OUT_REG) begin : g_lat
        // Operand copy aligned with the registered outputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
                vld <= 1'b0;
            end else begin
                a_q <= op_a;
                b_q <= op_b;
                vld <= 1'b1;
            end
        end

        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |=> (prod == '0 && prod_rnd == '0)); // R1
    end else begin : g_nolat
        assign a_q = op_a;
        assign b_q = op_b;
        assign vld = rst_n;
    end

    // Signed error of the scaled output against the exact product.
    always_comb begin
        err = longint'($signed(prod)) * ULP - longint'($signed(a_q)) * longint'($signed(b_q));
    end

    // Reference rounding of the truncated output.
    function automatic logic [N-1:0] rnd_ref(input logic [N+K-1:0] v);
        logic [N+K:0] t;
        t = {1'b0, v};
        if (K > 0) begin
            t = t + ((N+K+1)'(1) << (K - 1));
        end
        return t[N+K-1:K];
    endfunction

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && (a_q == '0 || b_q == '0)) |-> (longint'(prod) == CQ)); // R3
    AST_ERR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (err <= C && err > C - LMAX - ULP)); // R4
    AST_RND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (prod_rnd == rnd_ref(prod))); // R5
    AST_MIN_SQUARED: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && a_q == MINV && b_q == MINV) |-> (longint'(prod) == MAXSQ)); // R7

endmodule

bind trunc_mul trunc_mul_chk #(.N(N), .R(R), .K(K), .OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod), .prod_rnd(prod_rnd)
);

// File: tb/trunc_mul_test.sv
`timescale 1ns/1ps
module trunc_mul_test;
    localparam int N = 8;
    localparam int R = 5;
    localparam int K = 2;
    localparam int W = 2 * N;
    localparam longint ULP = longint'(1) << (N - K);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   op_a = '0;
    logic [N-1:0]   op_b = '0;
    logic [N+K-1:0] prod;
    logic [N-1:0]   prod_rnd;

    int     n_chk = 0;
    int     n_bad = 0;
    longint cb;
    longint lmax;

    always #2.5 clk = ~clk;

    trunc_mul #(.N(N), .R(R), .K(K), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod), .prod_rnd(prod_rnd)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Full product minus the dropped columns plus the bias, then truncated.
    function automatic logic [N+K-1:0] ref_trunc(input logic [N-1:0] a, input logic [N-1:0] b);
        longint p;
        longint l;
        logic [63:0] s;
        p = longint'($signed(a)) * longint'($signed(b));
        l = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (i + j < R && a[i] && b[j]) l += longint'(1) << (i + j);
        s = p - l + cb;
        return s[W-1:N-K];
    endfunction

    function automatic logic [N-1:0] ref_rnd(input logic [N+K-1:0] t);
        logic [N+K-1:0] v;
        v = t + ((N+K)'(1) << (K - 1));
        return v[N+K-1:K];
    endfunction

    // Drive one operand pair and check both outputs one cycle later (R2, R5).
    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input string req);
        logic [N+K-1:0] et;
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
        et = ref_trunc(a, b);
        check(prod == et, req, longint'(prod), longint'(et));
        check(prod_rnd == ref_rnd(et), "R5", longint'(prod_rnd), longint'(ref_rnd(et)));
    endtask

    task automatic t_reset;
        op_a = 8'h5a;
        op_b = 8'h33;
        repeat (3) @(negedge clk);
        check(prod == '0, "R1", longint'(prod), 0);
        check(prod_rnd == '0, "R1", longint'(prod_rnd), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_zero;
        logic [N-1:0] v [4] = '{8'h01, 8'h7f, 8'h80, 8'hc3};
        for (int i = 0; i < 4; i++) begin
            apply('0, v[i], "R3");
            check(longint'(prod) == (cb >> (N - K)), "R3", longint'(prod), cb >> (N - K));
            apply(v[i], '0, "R3");
        end
    endtask

    task automatic t_corners;
        apply(8'h80, 8'h80, "R7");
        check(prod == 10'h101, "R7", longint'(prod), 'h101);
        apply(8'h80, 8'h7f, "R7");
        apply(8'h7f, 8'h7f, "R7");
        apply(8'h7f, 8'h80, "R7");
        apply(8'hff, 8'hff, "R2");
        apply(8'h01, 8'h01, "R2");
        apply(8'hff, 8'h80, "R7");
    endtask

    task automatic t_random(input int cnt);
        longint e;
        for (int i = 0; i < cnt; i++) begin
            logic [N-1:0] a = N'($urandom);
            logic [N-1:0] b = N'($urandom);
            apply(a, b, "R2");
            e = longint'($signed(prod)) * ULP - longint'($signed(a)) * longint'($signed(b));
            check(e <= cb && e > cb - lmax - ULP, "R4", e, cb);
        end
    endtask

    task automatic t_mean(input int cnt);
        longint acc = 0;
        for (int i = 0; i < cnt; i++) begin
            logic [N-1:0] a = N'($urandom);
            logic [N-1:0] b = N'($urandom);
            @(negedge clk);
            op_a = a;
            op_b = b;
            @(negedge clk);
            acc += longint'($signed(prod)) * ULP - longint'($signed(a)) * longint'($signed(b));
        end
        check((acc < 0 ? -acc : acc) <= longint'(cnt) * ULP, "R6", acc, longint'(cnt) * ULP);
    endtask

    initial begin
        cb = longint'($floor(((R - 1) * (2.0 ** (R - 2)) + 0.25) / (2.0 ** (N - K)) + 0.5)) << (N - K);
        lmax = longint'(R - 1) * (longint'(1) << R) + 1;
        t_reset();
        t_zero();
        t_corners();
        t_random(400);
        t_mean(4000);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule